// File: doc/BRIEF.md
# Voice Group Playback Sequencer

The sequencer plays one voice group from on-chip sample storage. Sample storage is a set of fixed-size blocks. A voice group is an ordered run of entries in a combination table that all groups share. Each entry names an inclusive range of blocks. Several groups can therefore reuse the same stored clip, in any order.

A start request carries a group number. The block reads a group-index ROM to find the group's first table entry. It then walks the entries until it reaches one marked as last. For each block in the current range it streams the bytes in order. All three memories are synchronous-read ports: data returns the cycle after the address. On each sample-tick strobe the block emits one sample code. The code is either a 4-bit ADPCM nibble or an 8-bit PCM byte, and the format is chosen at start.

An optional ramp mode slews an 8-bit level from mid-scale to the first sample before playback and back to mid-scale after it. This suppresses clicks at the analogue output. A done pulse marks the end of playback. An abort input halts playback at once.

Top module: `voice_seq`

## Requirements
- R1: After reset `busy_o`, `sample_valid_o`, `ramp_o` and `done_o` are all low.
- R2: A start reads the index ROM at the group number to get the first entry. Each entry is 17 bits: bit 16 is the last-entry flag, bits 15:8 the end block and bits 7:0 the start block. Blocks start..end are played in ascending order, each at offsets 0 to BLK_BYTES-1, with memory address = block*BLK_BYTES + offset. After the block range, the next entry is at entry address + 1, until an entry with the last flag has been played. Start must not exceed end.
- R3: In PCM mode (`adpcm_i`=0 at start) each byte gives one sample, and `sample_o` equals the byte.
- R4: In ADPCM mode each byte gives two samples, high nibble first. The nibble is on `sample_o[3:0]` and `sample_o[7:4]` is zero.
- R5: An output is valid for one cycle, in the cycle after a tick. With ticks at least 6 clocks apart, every tick from the first output up to done yields exactly one output. Ticks before the first byte is fetched yield nothing.
- R6: `done_o` pulses for one cycle on the tick after the final output, and `busy_o` falls in that same cycle.
- R7: With `ramp_en_i`=1 at start, RAMP_LEN ramp outputs (`ramp_o`=1) precede the first sample, for k = 0..RAMP_LEN-1. Each level is (128 + ((T-128)*k >>> log2 RAMP_LEN)) mod 256. T is the first sample left-aligned to 8 bits: the byte in PCM, nibble<<4 in ADPCM.
- R8: With ramp on, the RAMP_LEN ticks after the last sample carry ramp outputs with k = RAMP_LEN-1 down to 0. These use the same formula with T = the last sample left-aligned. Done follows on the next tick.
- R9: In the cycle after `abort_i` is high, `busy_o`, `sample_valid_o` and `done_o` are low, and nothing more is emitted. A later start plays normally. Abort wins over a start in the same cycle.
- R10: A start while `busy_o` is high is ignored, together with its group, format and ramp inputs.
- R11: Groups that share table entries, or that list ranges in non-ascending block order, play each range as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| group_i | input | GRP_W | Group number for the start |
| abort_i | input | 1 | Stop playback immediately |
| tick_i | input | 1 | Sample-rate strobe |
| adpcm_i | input | 1 | 1: 4-bit ADPCM data, 0: 8-bit PCM (sampled at start) |
| ramp_en_i | input | 1 | Enable start/end ramp (sampled at start) |
| gidx_addr_o | output | GRP_W | Group-index ROM address |
| gidx_data_i | input | ENT_W | Group-index ROM data (first entry) |
| tbl_addr_o | output | ENT_W | Combination table address |
| tbl_data_i | input | 17 | Table entry {last, end, start} |
| mem_addr_o | output | 8+log2 BLK_BYTES | Sample memory address |
| mem_data_i | input | 8 | Sample memory data |
| sample_o | output | 8 | Sample code or ramp level |
| sample_valid_o | output | 1 | Output strobe |
| ramp_o | output | 1 | Output is a ramp level |
| done_o | output | 1 | Playback finished |
| busy_o | output | 1 | Playback in progress |

## Verification
The bench builds the block with BLK_BYTES=4 and RAMP_LEN=8, and keeps the 5-bit group and 10-bit entry widths. Four-byte blocks let a group cross several block and entry boundaries within a few dozen ticks, so multi-entry groups, reversed ranges and shared entries are all covered. The 8-tick ramp reaches both ramp directions and the last-sample-to-done timing quickly. Using the full 512-byte, 64-tick defaults would make each of those transitions hundreds of ticks long.

// File: rtl/vs_pkg.sv
package vs_pkg;
  localparam int BLK_W = 8;

  typedef struct packed {
    logic             last;
    logic [BLK_W-1:0] end_blk;
    logic [BLK_W-1:0] start_blk;
  } entry_t;

  typedef enum logic [3:0] {
    W_IDLE, W_GIDX, W_GDAT, W_TBL, W_TDAT, W_MEM, W_MDAT, W_HOLD, W_END
  } walk_st_e;

  typedef enum logic [2:0] {
    E_IDLE, E_RUP, E_PLAY, E_RDN, E_FIN
  } emit_st_e;
endpackage

// File: rtl/vs_ramp.sv
module vs_ramp #(
  parameter int K_W = 6
) (
  input  logic [7:0]     tgt_i,
  input  logic [K_W-1:0] k_i,
  output logic [7:0]     lvl_o
);
  localparam int PW = K_W + 11;

  logic signed [9:0]    diff;
  logic signed [PW-1:0] dext, kext, prod, shf;

  assign diff  = $signed({2'b00, tgt_i}) - 10'sd128;
  assign dext  = {{(PW-10){diff[9]}}, diff};
  assign kext  = {{(PW-K_W){1'b0}}, k_i};
  assign prod  = dext * kext;
  assign shf   = prod >>> K_W;
  // shf lies in [-128,127]; adding mid-scale mod 256 gives the level
  assign lvl_o = shf[7:0] + 8'h80;
endmodule

// File: rtl/vs_walker.sv
module vs_walker import vs_pkg::*; #(
  parameter int GRP_W  = 5,
  parameter int ENT_W  = 10,
  parameter int OFF_W  = 9,
  parameter int ADDR_W = BLK_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              go_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              take_i,
  output logic [GRP_W-1:0]  gidx_addr_o,
  input  logic [ENT_W-1:0]  gidx_data_i,
  output logic [ENT_W-1:0]  tbl_addr_o,
  input  logic [2*BLK_W:0]  tbl_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic [7:0]        byte_o,
  output logic              byte_ok_o,
  output logic              fin_o
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  walk_st_e         st_q;
  logic [GRP_W-1:0] grp_q;
  logic [ENT_W-1:0] ent_q;
  logic [BLK_W-1:0] blk_q, end_q;
  logic [OFF_W-1:0] off_q;
  logic             last_q, eof_q, need_tbl_q;
  entry_t           ent_rd;

  assign ent_rd      = entry_t'(tbl_data_i);
  assign gidx_addr_o = grp_q;
  assign tbl_addr_o  = ent_q;
  assign mem_addr_o  = {blk_q, off_q};
  assign fin_o       = (st_q == W_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= W_IDLE; grp_q <= '0; ent_q <= '0; blk_q <= '0; end_q <= '0;
      off_q <= '0; last_q <= 1'b0; eof_q <= 1'b0; need_tbl_q <= 1'b0;
      byte_o <= '0; byte_ok_o <= 1'b0;
    end else if (clr_i) begin
      st_q <= W_IDLE; byte_ok_o <= 1'b0; eof_q <= 1'b0;
    end else if (go_i) begin
      grp_q <= grp_i; st_q <= W_GIDX; byte_ok_o <= 1'b0; eof_q <= 1'b0;
    end else begin
      case (st_q)
        W_GIDX: st_q <= W_GDAT;
        W_GDAT: begin ent_q <= gidx_data_i; st_q <= W_TBL; end
        W_TBL:  st_q <= W_TDAT;
        W_TDAT: begin
          blk_q  <= ent_rd.start_blk;
          end_q  <= ent_rd.end_blk;
          last_q <= ent_rd.last;
          off_q  <= '0;
          st_q   <= W_MEM;
        end
        W_MEM:  st_q <= W_MDAT;
        W_MDAT: begin
          byte_o     <= mem_data_i;
          byte_ok_o  <= 1'b1;
          need_tbl_q <= 1'b0;
          off_q      <= off_q + 1'b1;
          if (off_q == OFF_MAX) begin
            if (blk_q == end_q) begin
              if (last_q) eof_q <= 1'b1;
              else begin ent_q <= ent_q + 1'b1; need_tbl_q <= 1'b1; end
            end else begin
              blk_q <= blk_q + 1'b1;
            end
          end
          st_q <= W_HOLD;
        end
        W_HOLD: if (take_i) begin
          byte_ok_o <= 1'b0;
          st_q <= eof_q ? W_END : (need_tbl_q ? W_TBL : W_MEM);
        end
        W_END:  st_q <= W_END;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  AST_TAKE_WITH_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (byte_ok_o && st_q == W_HOLD)); // R5
  AST_BLK_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_MEM) |-> (blk_q <= end_q)); // R2
endmodule

// File: rtl/vs_emitter.sv
module vs_emitter import vs_pkg::*; #(
  parameter int K_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_i,
  input  logic       start_i,
  input  logic       adpcm_i,
  input  logic       ramp_en_i,
  input  logic       tick_i,
  input  logic [7:0] byte_i,
  input  logic       byte_ok_i,
  input  logic       fin_i,
  output logic       take_o,
  output logic [7:0] sample_o,
  output logic       sample_valid_o,
  output logic       ramp_o,
  output logic       done_o,
  output logic       busy_o
);
  localparam logic [K_W-1:0] K_MAX = '1;

  emit_st_e       st_q;
  logic           adpcm_q, ramp_q, lo_pend_q;
  logic [7:0]     hold_q, last_q;
  logic [K_W-1:0] k_q, rk;
  logic [7:0]     up_tgt, rtgt, lvl;

  assign busy_o = (st_q != E_IDLE);
  assign up_tgt = adpcm_q ? {byte_i[7:4], 4'h0} : byte_i;
  assign rtgt   = (st_q == E_RUP) ? up_tgt : last_q;
  assign rk     = (st_q == E_PLAY) ? K_MAX : k_q;
  assign take_o = tick_i && !abort_i && (st_q == E_PLAY) && !lo_pend_q && byte_ok_i;

  vs_ramp #(.K_W(K_W)) u_ramp (.tgt_i(rtgt), .k_i(rk), .lvl_o(lvl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= E_IDLE; adpcm_q <= 1'b0; ramp_q <= 1'b0; lo_pend_q <= 1'b0;
      hold_q <= '0; last_q <= '0; k_q <= '0;
      sample_o <= '0; sample_valid_o <= 1'b0; ramp_o <= 1'b0; done_o <= 1'b0;
    end else begin
      sample_valid_o <= 1'b0; ramp_o <= 1'b0; done_o <= 1'b0;
      if (abort_i) begin
        st_q <= E_IDLE; lo_pend_q <= 1'b0;
      end else begin
        case (st_q)
          E_IDLE: if (start_i) begin
            adpcm_q <= adpcm_i; ramp_q <= ramp_en_i; k_q <= '0; lo_pend_q <= 1'b0;
            st_q <= ramp_en_i ? E_RUP : E_PLAY;
          end
          E_RUP: if (tick_i && byte_ok_i) begin
            sample_valid_o <= 1'b1; ramp_o <= 1'b1; sample_o <= lvl;
            if (k_q == K_MAX) st_q <= E_PLAY;
            else k_q <= k_q + 1'b1;
          end
          E_PLAY: if (tick_i) begin
            if (lo_pend_q) begin
              sample_valid_o <= 1'b1; sample_o <= {4'h0, hold_q[3:0]};
              last_q <= {hold_q[3:0], 4'h0}; lo_pend_q <= 1'b0;
            end else if (byte_ok_i) begin
              sample_valid_o <= 1'b1; hold_q <= byte_i;
              if (adpcm_q) begin
                sample_o <= {4'h0, byte_i[7:4]}; last_q <= {byte_i[7:4], 4'h0};
                lo_pend_q <= 1'b1;
              end else begin
                sample_o <= byte_i; last_q <= byte_i;
              end
            end else if (fin_i) begin
              if (ramp_q) begin
                sample_valid_o <= 1'b1; ramp_o <= 1'b1; sample_o <= lvl;
                k_q <= K_MAX - 1'b1; st_q <= E_RDN;
              end else begin
                done_o <= 1'b1; st_q <= E_IDLE;
              end
            end
          end
          E_RDN: if (tick_i) begin
            sample_valid_o <= 1'b1; ramp_o <= 1'b1; sample_o <= lvl;
            if (k_q == '0) st_q <= E_FIN;
            else k_q <= k_q - 1'b1;
          end
          E_FIN: if (tick_i) begin done_o <= 1'b1; st_q <= E_IDLE; end
          default: st_q <= E_IDLE;
        endcase
      end
    end
  end

  AST_VALID_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> $past(tick_i)); // R5
  AST_DONE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(tick_i) && !busy_o && !sample_valid_o)); // R6
  AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(abort_i) |-> (!sample_valid_o && !done_o && !busy_o)); // R9
  AST_NIBBLE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && !ramp_o && adpcm_q) |-> (sample_o[7:4] == 4'h0)); // R4
endmodule

// File: rtl/voice_seq.sv
module voice_seq import vs_pkg::*; #(
  parameter int GRP_W     = 5,
  parameter int ENT_W     = 10,
  parameter int BLK_BYTES = 512,
  parameter int RAMP_LEN  = 64,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int ADDR_W   = BLK_W + OFF_W,
  localparam int K_W      = $clog2(RAMP_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [GRP_W-1:0]  group_i,
  input  logic              abort_i,
  input  logic              tick_i,
  input  logic              adpcm_i,
  input  logic              ramp_en_i,
  output logic [GRP_W-1:0]  gidx_addr_o,
  input  logic [ENT_W-1:0]  gidx_data_i,
  output logic [ENT_W-1:0]  tbl_addr_o,
  input  logic [2*BLK_W:0]  tbl_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic [7:0]        sample_o,
  output logic              sample_valid_o,
  output logic              ramp_o,
  output logic              done_o,
  output logic              busy_o
);
  logic       start_acc, take, byte_ok, fin;
  logic [7:0] byte_d;

  assign start_acc = start_i && !abort_i && !busy_o;

  vs_walker #(.GRP_W(GRP_W), .ENT_W(ENT_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_walker (
    .clk_i, .rst_ni, .clr_i(abort_i), .go_i(start_acc), .grp_i(group_i),
    .take_i(take), .gidx_addr_o, .gidx_data_i, .tbl_addr_o, .tbl_data_i,
    .mem_addr_o, .mem_data_i, .byte_o(byte_d), .byte_ok_o(byte_ok), .fin_o(fin)
  );

  vs_emitter #(.K_W(K_W)) u_emitter (
    .clk_i, .rst_ni, .abort_i, .start_i(start_acc), .adpcm_i, .ramp_en_i, .tick_i,
    .byte_i(byte_d), .byte_ok_i(byte_ok), .fin_i(fin), .take_o(take),
    .sample_o, .sample_valid_o, .ramp_o, .done_o, .busy_o
  );
endmodule

// File: tb/voice_seq_tb.sv
`timescale 1ns/1ps
module voice_seq_tb;
  localparam int BB  = 4;
  localparam int RL  = 8;
  localparam int RSH = 3;

  logic clk = 0, rst_n = 0;
  logic start = 0, abort = 0, tick = 0, adpcm = 0, ramp_en = 0;
  logic [4:0]  group = '0;
  logic [4:0]  gidx_addr;
  logic [9:0]  gidx_data, tbl_addr, mem_addr;
  logic [16:0] tbl_data;
  logic [7:0]  mem_data, sample;
  logic        valid, ramp, done, busy;

  logic [9:0]  gidx_rom [32];
  logic [16:0] tbl_rom  [1024];
  logic [7:0]  dmem     [1024];

  int n_chk = 0, n_err = 0;
  int exp_q[$];
  string tag_q[$];
  int n_items, tick_cnt = 0, last_out_tick = 0, first_tick = 0, done_tick = 0;
  int done_cnt = 0, out_cnt = 0;
  bit first_pending = 0, finished = 0;

  always #10 clk = ~clk;

  voice_seq #(.BLK_BYTES(BB), .RAMP_LEN(RL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .group_i(group), .abort_i(abort),
    .tick_i(tick), .adpcm_i(adpcm), .ramp_en_i(ramp_en),
    .gidx_addr_o(gidx_addr), .gidx_data_i(gidx_data), .tbl_addr_o(tbl_addr),
    .tbl_data_i(tbl_data), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .sample_o(sample), .sample_valid_o(valid), .ramp_o(ramp), .done_o(done), .busy_o(busy)
  );

  always @(posedge clk) begin
    gidx_data <= gidx_rom[gidx_addr];
    tbl_data  <= tbl_rom[tbl_addr];
    mem_data  <= dmem[mem_addr];
  end

  function automatic logic [16:0] ent(int s, int e, int l);
    return {1'(l), 8'(e), 8'(s)};
  endfunction

  function automatic int lvl(int t, int k);
    return (128 + (((t - 128) * k) >>> RSH)) & 255;
  endfunction

  task automatic chk(bit ok, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int got;
      if (tick) tick_cnt++;
      if (valid || done) begin
        got = done ? 512 : (ramp ? 256 : 0) + int'(sample);
        if (first_pending) begin first_tick = tick_cnt; first_pending = 0; end
        if (exp_q.size() == 0) begin
          chk(0, "R9/R10 unexpected output", got, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(got == e, t, got, e);
        end
        if (done) begin
          done_cnt++;
          done_tick = tick_cnt;
          chk(tick_cnt == last_out_tick + 1, "R6 done on tick after last output",
              tick_cnt - last_out_tick, 1);
        end else begin
          out_cnt++;
          last_out_tick = tick_cnt;
        end
      end
    end
  end

  initial begin
    int tc = 0;
    @(posedge rst_n);
    forever begin
      @(posedge clk); #2;
      tick = (tc == 7);
      tc = (tc + 1) % 8;
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog expired", cyc, 150000);
        summary();
      end
    end
  end

  task automatic build(int g, bit adp, bit rmp, string tag);
    int codes[$];
    int e;
    logic [16:0] t;
    exp_q.delete(); tag_q.delete();
    e = int'(gidx_rom[g]);
    while (1) begin
      t = tbl_rom[e];
      for (int b = int'(t[7:0]); b <= int'(t[15:8]); b++)
        for (int o = 0; o < BB; o++) begin
          int by;
          by = int'(dmem[b*BB + o]);
          if (adp) begin codes.push_back(by >> 4); codes.push_back(by & 15); end
          else codes.push_back(by);
        end
      if (t[16]) break;
      e++;
    end
    if (rmp) begin
      int fa;
      fa = adp ? codes[0] << 4 : codes[0];
      for (int k = 0; k < RL; k++) begin
        exp_q.push_back(256 + lvl(fa, k)); tag_q.push_back({"R7 ramp-up ", tag});
      end
    end
    foreach (codes[i]) begin
      exp_q.push_back(codes[i]);
      tag_q.push_back({adp ? "R4 ADPCM " : "R3 PCM ", tag});
    end
    if (rmp) begin
      int la;
      la = adp ? codes[codes.size()-1] << 4 : codes[codes.size()-1];
      for (int k = RL - 1; k >= 0; k--) begin
        exp_q.push_back(256 + lvl(la, k)); tag_q.push_back({"R8 ramp-down ", tag});
      end
    end
    exp_q.push_back(512); tag_q.push_back({"R6 done ", tag});
    n_items = exp_q.size();
  endtask

  task automatic pulse_start(int g, bit adp, bit rmp);
    @(posedge clk); #2;
    group = 5'(g); adpcm = adp; ramp_en = rmp; start = 1;
    @(posedge clk); #2;
    start = 0;
  endtask

  task automatic play(int g, bit adp, bit rmp, string tag, int poke_at);
    int prev, cyc;
    build(g, adp, rmp, tag);
    first_pending = 1;
    prev = done_cnt;
    pulse_start(g, adp, rmp);
    cyc = 0;
    while (done_cnt == prev && cyc < 30000) begin
      @(posedge clk); #2;
      cyc++;
      if (poke_at > 0 && cyc == poke_at) begin
        start = 1; group = 5'd5; adpcm = !adp; ramp_en = !rmp;
      end else start = 0;
    end
    start = 0;
    chk(done_cnt != prev, {"R6 playback completes ", tag}, done_cnt - prev, 1);
    chk(exp_q.size() == 0, {"R2 stream length ", tag}, exp_q.size(), 0);
    chk(done_tick - first_tick + 1 == n_items, {"R5 one output per tick ", tag},
        done_tick - first_tick + 1, n_items);
    chk(busy == 0, {"R6 busy low after done ", tag}, busy, 0);
    repeat (10) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) gidx_rom[i] = '0;
    for (int i = 0; i < 1024; i++) begin
      tbl_rom[i] = ent(0, 0, 1);
      dmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    end
    // group 1: blocks 3..4 then 0..1 (R11 reversed order)
    tbl_rom[0] = ent(3, 4, 0); tbl_rom[1] = ent(0, 1, 1);
    tbl_rom[2] = ent(2, 2, 1);
    tbl_rom[3] = ent(5, 5, 0); tbl_rom[4] = ent(7, 7, 0); tbl_rom[5] = ent(6, 6, 1);
    gidx_rom[1] = 10'd0;
    gidx_rom[2] = 10'd2;
    gidx_rom[3] = 10'd1;  // shares entry 1 with group 1 (R11)
    gidx_rom[5] = 10'd3;

    repeat (5) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(valid == 0, "R1 valid after reset", valid, 0);
    chk(done == 0, "R1 done after reset", done, 0);
    chk(ramp == 0, "R1 ramp after reset", ramp, 0);

    play(1, 0, 0, "R2 R11 group1 pcm", 0);
    play(1, 1, 0, "R2 group1 adpcm", 0);
    play(3, 0, 1, "R11 group3 pcm ramp", 0);
    play(5, 1, 1, "R2 group5 adpcm ramp", 0);
    play(2, 1, 1, "R7 R8 group2 adpcm ramp", 0);

    // R9: abort mid-playback
    begin
      int base, quiet;
      build(1, 0, 0, "R9 before abort");
      pulse_start(1, 0, 0);
      base = out_cnt;
      while (out_cnt < base + 3) @(negedge clk);
      @(posedge clk); #2 abort = 1;
      @(posedge clk); #2 abort = 0;
      exp_q.delete(); tag_q.delete();
      @(negedge clk);
      chk(busy == 0, "R9 busy low after abort", busy, 0);
      chk(valid == 0 && done == 0, "R9 no output after abort", valid | done, 0);
      quiet = out_cnt;
      repeat (80) @(negedge clk);
      chk(out_cnt == quiet, "R9 silence after abort", out_cnt - quiet, 0);
      // abort and start in the same cycle: abort wins
      @(posedge clk); #2 abort = 1; start = 1; group = 5'd2;
      @(posedge clk); #2 abort = 0; start = 0;
      @(negedge clk);
      chk(busy == 0, "R9 abort beats start", busy, 0);
      repeat (10) @(posedge clk);
    end
    play(2, 0, 0, "R9 play after abort", 0);

    // R10: start while busy ignored
    play(1, 0, 0, "R10 start while busy", 40);
    play(3, 1, 0, "R10 adpcm start while busy", 25);

    summary();
  end
endmodule